// File: doc/BRIEF.md
# Auxiliary System Control Register Block

This block gathers the small control registers of a workstation I/O companion device behind a plain register bus. Software uses it to configure the device, to keep diagnostic bytes and a 16-bit LED pattern, to drive modem control lines, to strobe the floppy controller's terminal-count line, to request a power-off or a system reset, and to field a power-fail interrupt.

Seven register windows share the bus. Each window has its own bit on a one-hot select input, and the register sits at byte offset 0 of that window. Writes take effect at the clock edge where `bus_wr` is high. Read data is combinational from the select and offset inputs. There is no data stream here, so every pin is a plain control or status signal with no valid/ready handshake.

Two resets exist. The device reset `rst_n` clears the volatile registers. The power-on reset `por_n` also clears the registers that must outlive a device reset, so that a reset-status flag can be read after the reset it asked for.

Top module: `aux_sysctl_regs`

## Requirements
- R1: While `rst_n` is low, the configuration, modem, aux-one and aux-two registers clear to 0. While `por_n` is low, every register clears to 0 and every output is low.
- R2: A `rst_n` pulse alone leaves the diagnostic, LED and system-control registers unchanged.
- R3: The configuration (window 0), diagnostic (window 1) and modem (window 2) registers are 8-bit read/write registers. The LED register (window 3) is 16-bit read/write, and write bits above 15 are dropped.
- R4: A write to aux-one (window 5) with bit 1 set raises `fdc_tc` for exactly the one cycle after the write. Bit 1 always reads back as 0, and the other seven bits read back as written.
- R5: A write to aux-two (window 6) keeps only data bits 0 (power-off) and 1 (interrupt clear) and merges in the current power-fail flag at bit 5. If bit 1 of the data is set, the stored value is data bit 0 alone, so the flag is cleared.
- R6: An aux-two write that stores the power-off bit raises `shutdown_req` for exactly the one cycle after the write.
- R7: A rise of `pwr_fail` while configuration bit 3 is set sets aux-two bit 5. Any other change of `pwr_fail` clears aux-two bit 5.
- R8: `pwr_irq` is high exactly when aux-two bit 5 and configuration bit 3 are both set. It follows each change of either bit one cycle after the causing edge.
- R9: A write to system control (window 4, offset 0) with bit 0 set loads the value 0x02 and raises `sys_reset_req` for one cycle. A write with bit 0 clear changes nothing.
- R10: A read returns 0 for a nonzero offset, for no select bit, or for more than one select bit, and a write in any of those cases changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Device reset, active low, asynchronous |
| por_n | input | 1 | Power-on reset, active low, asynchronous; clears all state |
| bus_wr | input | 1 | Write strobe for the current access |
| bus_sel | input | 7 | One-hot window select (0 cfg, 1 diag, 2 modem, 3 LED, 4 sysctl, 5 aux-one, 6 aux-two) |
| bus_ofs | input | 2 | Byte offset within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero-extended |
| pwr_fail | input | 1 | Power-fail level from the supply |
| pwr_irq | output | 1 | Power-fail interrupt |
| fdc_tc | output | 1 | Floppy terminal-count pulse |
| shutdown_req | output | 1 | Power-off request pulse |
| sys_reset_req | output | 1 | System reset request pulse |

## Verification
The hardest state to reach is an aux-two write that lands while the power-fail flag is already set. The flag can only be set through an enabled rise of `pwr_fail`, and a write with the clear bit or a fall of the input both remove it. The bench therefore arms the enable, raises the input, and only then issues each of the four power-off/clear combinations with junk in the upper data bits. It checks the merged value and the shutdown pulse, and then lowers the input before the next combination. The same enable-before-rise ordering is swept with the enable both set and clear, to show that a disabled rise leaves no flag behind.

// File: rtl/aux_sysctl_pkg.sv
package aux_sysctl_pkg;
  localparam int NWIN     = 7;
  localparam int W_CFG    = 0;
  localparam int W_DIAG   = 1;
  localparam int W_MODEM  = 2;
  localparam int W_LED    = 3;
  localparam int W_SYS    = 4;
  localparam int W_AUX1   = 5;
  localparam int W_AUX2   = 6;

  localparam int PIE_BIT  = 3;  // cfg: power interrupt enable
  localparam int PF_BIT   = 5;  // aux2: power-fail flag
  localparam int POFF_BIT = 0;  // aux2: power off
  localparam int PCLR_BIT = 1;  // aux2: interrupt clear
  localparam int TC_BIT   = 1;  // aux1: terminal count strobe
  localparam int SRST_BIT = 0;  // sysctl: reset request
  localparam logic [7:0] RSTAT_VAL = 8'h02;
endpackage

// File: rtl/aux_pwr_ctl.sv
module aux_pwr_ctl
  import aux_sysctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       por_n,
  input  logic       wr_cfg,
  input  logic       wr_aux2,
  input  logic [7:0] wdata,
  input  logic       pf_in,
  output logic [7:0] cfg_q,
  output logic [7:0] aux2_q,
  output logic       pwr_irq,
  output logic       shutdown_req
);
  logic       pf_q;
  logic       flag_n;
  logic [7:0] aux2_n;
  logic       rst_all_n;

  assign rst_all_n = rst_n & por_n;

  always_comb begin
    flag_n = (pf_in != pf_q) ? (pf_in & cfg_q[PIE_BIT]) : aux2_q[PF_BIT];
    aux2_n = aux2_q;
    aux2_n[PF_BIT] = flag_n;
    if (wr_aux2) begin
      aux2_n = '0;
      aux2_n[PF_BIT]   = flag_n;
      aux2_n[POFF_BIT] = wdata[POFF_BIT];
      aux2_n[PCLR_BIT] = wdata[PCLR_BIT];
      if (wdata[PCLR_BIT]) begin
        aux2_n = '0;
        aux2_n[POFF_BIT] = wdata[POFF_BIT];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_all_n) begin
    if (!rst_all_n) begin
      cfg_q        <= '0;
      aux2_q       <= '0;
      pf_q         <= 1'b0;
      shutdown_req <= 1'b0;
    end else begin
      pf_q         <= pf_in;
      aux2_q       <= aux2_n;
      shutdown_req <= wr_aux2 & aux2_n[POFF_BIT];
      if (wr_cfg) cfg_q <= wdata;
    end
  end

  assign pwr_irq = aux2_q[PF_BIT] & cfg_q[PIE_BIT];

  a_r7_flag_needs_enable: assert property (@(posedge clk) disable iff (!rst_all_n)
    $rose(aux2_q[PF_BIT]) |-> $past(cfg_q[PIE_BIT]));
  a_r5_clear_wins: assert property (@(posedge clk) disable iff (!rst_all_n)
    (wr_aux2 && wdata[PCLR_BIT]) |=> (aux2_q[7:1] == 7'd0));
  a_r6_shutdown_src: assert property (@(posedge clk) disable iff (!rst_all_n)
    shutdown_req |-> aux2_q[POFF_BIT]);
endmodule

// File: rtl/aux_misc_regs.sv
module aux_misc_regs
  import aux_sysctl_pkg::*;
#(
  parameter int LED_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             por_n,
  input  logic             wr_diag,
  input  logic             wr_modem,
  input  logic             wr_led,
  input  logic             wr_sys,
  input  logic             wr_aux1,
  input  logic [LED_W-1:0] wdata,
  output logic [7:0]       diag_q,
  output logic [7:0]       modem_q,
  output logic [LED_W-1:0] led_q,
  output logic [7:0]       sys_q,
  output logic [7:0]       aux1_q,
  output logic             fdc_tc,
  output logic             sys_reset_req
);
  logic rst_all_n;
  assign rst_all_n = rst_n & por_n;

  // Volatile group: cleared by either reset
  always_ff @(posedge clk or negedge rst_all_n) begin
    if (!rst_all_n) begin
      modem_q       <= '0;
      aux1_q        <= '0;
      fdc_tc        <= 1'b0;
      sys_reset_req <= 1'b0;
    end else begin
      fdc_tc        <= wr_aux1 & wdata[TC_BIT];
      sys_reset_req <= wr_sys & wdata[SRST_BIT];
      if (wr_modem) modem_q <= wdata[7:0];
      if (wr_aux1) begin
        aux1_q         <= wdata[7:0];
        aux1_q[TC_BIT] <= 1'b0;
      end
    end
  end

  // Retained group: cleared only at power-on
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      diag_q <= '0;
      led_q  <= '0;
      sys_q  <= '0;
    end else begin
      if (wr_diag) diag_q <= wdata[7:0];
      if (wr_led)  led_q  <= wdata;
      if (wr_sys && wdata[SRST_BIT]) sys_q <= RSTAT_VAL;
    end
  end

  a_r4_tc_pulse: assert property (@(posedge clk) disable iff (!rst_all_n)
    (wr_aux1 && wdata[TC_BIT]) |=> fdc_tc);
  a_r9_req_status: assert property (@(posedge clk) disable iff (!rst_all_n)
    sys_reset_req |-> (sys_q == RSTAT_VAL));
  a_r9_no_req_bit0_clear: assert property (@(posedge clk) disable iff (!rst_all_n)
    (wr_sys && !wdata[SRST_BIT]) |=> !sys_reset_req);
endmodule

// File: rtl/aux_rd_mux.sv
module aux_rd_mux
  import aux_sysctl_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                  hit_ok,
  input  logic [NWIN-1:0]       sel,
  input  logic [NWIN-1:0][DATA_W-1:0] win_data,
  output logic [DATA_W-1:0]     rdata
);
  logic [NWIN:0][DATA_W-1:0] acc;

  assign acc[0] = '0;
  for (genvar i = 0; i < NWIN; i++) begin : g_or
    assign acc[i+1] = acc[i] | (sel[i] ? win_data[i] : '0);
  end

  assign rdata = hit_ok ? acc[NWIN] : '0;

  always_comb begin
    a_r10_miss_reads_zero: assert (hit_ok || rdata == '0);
  end
endmodule

// File: rtl/aux_sysctl_regs.sv
module aux_sysctl_regs
  import aux_sysctl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OFS_W  = 2,
  parameter int LED_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_n,
  input  logic              bus_wr,
  input  logic [NWIN-1:0]   bus_sel,
  input  logic [OFS_W-1:0]  bus_ofs,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              pwr_fail,
  output logic              pwr_irq,
  output logic              fdc_tc,
  output logic              shutdown_req,
  output logic              sys_reset_req
);
  logic            hit_ok;
  logic [NWIN-1:0] wr_hit;
  logic [7:0]      cfg_q, aux2_q, diag_q, modem_q, sys_q, aux1_q;
  logic [LED_W-1:0] led_q;
  logic [NWIN-1:0][DATA_W-1:0] win_data;
  logic            unused_hi;

  assign hit_ok    = $onehot(bus_sel) && (bus_ofs == '0);
  assign unused_hi = ^bus_wdata[DATA_W-1:LED_W];

  for (genvar i = 0; i < NWIN; i++) begin : g_wr
    assign wr_hit[i] = bus_wr & hit_ok & bus_sel[i];
  end

  aux_pwr_ctl u_pwr (
    .clk          (clk),
    .rst_n        (rst_n),
    .por_n        (por_n),
    .wr_cfg       (wr_hit[W_CFG]),
    .wr_aux2      (wr_hit[W_AUX2]),
    .wdata        (bus_wdata[7:0]),
    .pf_in        (pwr_fail),
    .cfg_q        (cfg_q),
    .aux2_q       (aux2_q),
    .pwr_irq      (pwr_irq),
    .shutdown_req (shutdown_req)
  );

  aux_misc_regs #(.LED_W(LED_W)) u_misc (
    .clk           (clk),
    .rst_n         (rst_n),
    .por_n         (por_n),
    .wr_diag       (wr_hit[W_DIAG]),
    .wr_modem      (wr_hit[W_MODEM]),
    .wr_led        (wr_hit[W_LED]),
    .wr_sys        (wr_hit[W_SYS]),
    .wr_aux1       (wr_hit[W_AUX1]),
    .wdata         (bus_wdata[LED_W-1:0]),
    .diag_q        (diag_q),
    .modem_q       (modem_q),
    .led_q         (led_q),
    .sys_q         (sys_q),
    .aux1_q        (aux1_q),
    .fdc_tc        (fdc_tc),
    .sys_reset_req (sys_reset_req)
  );

  assign win_data[W_CFG]   = DATA_W'(cfg_q);
  assign win_data[W_DIAG]  = DATA_W'(diag_q);
  assign win_data[W_MODEM] = DATA_W'(modem_q);
  assign win_data[W_LED]   = DATA_W'(led_q);
  assign win_data[W_SYS]   = DATA_W'(sys_q);
  assign win_data[W_AUX1]  = DATA_W'(aux1_q);
  assign win_data[W_AUX2]  = DATA_W'(aux2_q);

  aux_rd_mux #(.DATA_W(DATA_W)) u_rd (
    .hit_ok   (hit_ok),
    .sel      (bus_sel),
    .win_data (win_data),
    .rdata    (bus_rdata)
  );
endmodule

// File: tb/aux_sysctl_regs_test.sv
module aux_sysctl_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0, por_n = 1'b0, bus_wr = 1'b0, pwr_fail = 1'b0;
  logic [6:0]  bus_sel = '0;
  logic [1:0]  bus_ofs = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        pwr_irq, fdc_tc, shutdown_req, sys_reset_req;
  int checks = 0, failures = 0, cyc = 0;

  always #5 clk = ~clk;

  aux_sysctl_regs uut (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
    .bus_ofs(bus_ofs), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pwr_fail(pwr_fail), .pwr_irq(pwr_irq), .fdc_tc(fdc_tc),
    .shutdown_req(shutdown_req), .sys_reset_req(sys_reset_req)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int win, logic [1:0] ofs, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_sel = 7'(1 << win); bus_ofs = ofs; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_sel = '0; bus_ofs = '0; bus_wdata = '0;
  endtask

  task automatic rd(int win, logic [1:0] ofs, output logic [31:0] d);
    bus_sel = 7'(1 << win); bus_ofs = ofs;
    #1 d = bus_rdata;
    bus_sel = '0; bus_ofs = '0;
  endtask

  task automatic set_pf(logic v);
    @(negedge clk); pwr_fail = v;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
      end
    end
  end

  initial begin
    logic [31:0] r;
    logic [31:0] exp_v;
    repeat (3) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    @(negedge clk);
    // R1: power-on state
    for (int w = 0; w < 7; w++) begin
      rd(w, 2'd0, r); chk("R1 por clear", r, 0);
    end
    chk("R1 outputs low", {pwr_irq, fdc_tc, shutdown_req, sys_reset_req}, 0);

    // R3: plain byte registers, full sweep
    for (int v = 0; v < 256; v++) begin
      for (int w = 0; w < 3; w++) begin
        wr(w, 2'd0, 32'(v) | 32'hFFFF_FF00 & 32'h0);
        rd(w, 2'd0, r); chk("R3 byte rw", r, 32'(v));
      end
    end
    wr(3, 2'd0, 32'hABCD_1234); rd(3, 2'd0, r); chk("R3 led drop high", r, 32'h1234);
    wr(3, 2'd0, 32'h0000_FFFF); rd(3, 2'd0, r); chk("R3 led rw", r, 32'hFFFF);

    // R4: aux-one sweep
    for (int v = 0; v < 256; v++) begin
      wr(5, 2'd0, 32'(v));
      chk("R4 tc pulse", 32'(fdc_tc), 32'((v >> 1) & 1));
      rd(5, 2'd0, r); chk("R4 aux1 readback", r, 32'(v & 8'hFD));
      @(negedge clk); chk("R4 tc one cycle", 32'(fdc_tc), 0);
    end

    // R7/R8: power-fail flag with enable set and clear
    for (int en = 0; en < 2; en++) begin
      wr(0, 2'd0, 32'(en << 3));
      set_pf(1'b1);
      rd(6, 2'd0, r); chk("R7 rise sets flag", r, 32'(en << 5));
      chk("R8 irq", 32'(pwr_irq), 32'(en));
      set_pf(1'b0);
      rd(6, 2'd0, r); chk("R7 fall clears flag", r, 0);
      chk("R8 irq low", 32'(pwr_irq), 0);
    end
    wr(0, 2'd0, 32'h08); set_pf(1'b1);
    wr(0, 2'd0, 32'h00);
    chk("R8 enable off masks irq", 32'(pwr_irq), 0);
    rd(6, 2'd0, r); chk("R8 flag kept", r, 32'h20);
    wr(0, 2'd0, 32'h08);
    chk("R8 enable on raises irq", 32'(pwr_irq), 1);
    set_pf(1'b0);

    // R5/R6: aux-two writes with flag clear and set
    for (int f = 0; f < 2; f++) begin
      for (int d = 0; d < 4; d++) begin
        wr(0, 2'd0, 32'h08);
        if (f == 1) set_pf(1'b1);
        wr(6, 2'd0, 32'hFC | 32'(d));
        chk("R6 shutdown pulse", 32'(shutdown_req), 32'(d & 1));
        exp_v = ((d & 2) != 0) ? 32'(d & 1) : (32'(f << 5) | 32'(d));
        rd(6, 2'd0, r); chk("R5 aux2 merge", r, exp_v);
        @(negedge clk); chk("R6 shutdown one cycle", 32'(shutdown_req), 0);
        set_pf(1'b0);
        wr(6, 2'd0, 32'h02);
      end
    end

    // R9: system control
    wr(4, 2'd0, 32'hFFFF_FFFE);
    chk("R9 no req bit0 clear", 32'(sys_reset_req), 0);
    rd(4, 2'd0, r); chk("R9 no effect", r, 0);
    wr(4, 2'd0, 32'h1);
    chk("R9 req pulse", 32'(sys_reset_req), 1);
    rd(4, 2'd0, r); chk("R9 status", r, 32'h02);
    @(negedge clk); chk("R9 req one cycle", 32'(sys_reset_req), 0);
    wr(4, 2'd0, 32'h0); rd(4, 2'd0, r); chk("R9 status kept", r, 32'h02);

    // R10: offsets and bad selects
    wr(0, 2'd0, 32'h11); wr(1, 2'd0, 32'h22); wr(2, 2'd0, 32'h33);
    wr(3, 2'd0, 32'h4444); wr(5, 2'd0, 32'h55); wr(6, 2'd0, 32'h02);
    for (int w = 0; w < 7; w++) begin
      for (int o = 1; o < 4; o++) begin
        wr(w, 2'(o), 32'hFF);
        rd(w, 2'(o), r); chk("R10 offset reads zero", r, 0);
      end
    end
    chk("R10 offset write no reset req", 32'(sys_reset_req), 0);
    @(negedge clk);
    bus_wr = 1'b1; bus_sel = 7'b0000011; bus_wdata = 32'h99;
    #1 chk("R10 multi select reads zero", bus_rdata, 0);
    @(negedge clk); bus_wr = 1'b0; bus_sel = '0;
    #1 chk("R10 no select reads zero", bus_rdata, 0);
    rd(0, 2'd0, r); chk("R10 cfg untouched", r, 32'h11);
    rd(1, 2'd0, r); chk("R10 diag untouched", r, 32'h22);
    rd(2, 2'd0, r); chk("R10 modem untouched", r, 32'h33);
    rd(3, 2'd0, r); chk("R10 led untouched", r, 32'h4444);
    rd(5, 2'd0, r); chk("R10 aux1 untouched", r, 32'h55);
    rd(6, 2'd0, r); chk("R10 aux2 untouched", r, 32'h00);

    // R1/R2: device reset only
    wr(6, 2'd0, 32'h01);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    rd(0, 2'd0, r); chk("R1 cfg cleared", r, 0);
    rd(2, 2'd0, r); chk("R1 modem cleared", r, 0);
    rd(5, 2'd0, r); chk("R1 aux1 cleared", r, 0);
    rd(6, 2'd0, r); chk("R1 aux2 cleared", r, 0);
    rd(1, 2'd0, r); chk("R2 diag kept", r, 32'h22);
    rd(3, 2'd0, r); chk("R2 led kept", r, 32'h4444);
    rd(4, 2'd0, r); chk("R2 sysctl kept", r, 32'h02);

    // R1: power-on reset clears retained group
    @(negedge clk); por_n = 1'b0;
    @(negedge clk); por_n = 1'b1;
    @(negedge clk);
    rd(1, 2'd0, r); chk("R1 por diag", r, 0);
    rd(4, 2'd0, r); chk("R1 por sysctl", r, 0);
    finish_run();
  end
endmodule